// File: doc/BRIEF.md
# Flash Program/Erase Busy Status Read Path

This block sits between the storage array and the data bus of a flash memory model. It starts internally timed byte-program and whole-array erase operations and keeps each one busy for a fixed, parameterised number of clock cycles. While an operation runs, reads on the bus do not return plain array contents. Two completion indicators are present at the same time. A polling bit carries the inverse of bit 7 of the byte being programmed when the programmed address is read. A toggle bit flips on every new read access. When the operation is over, both indicators stop and the array data goes out unchanged.

The bus strobes are the active-low chip select `ce_n` and output enable `oe_n`. An access is in progress while both are low. A new access begins on the clock where that condition first becomes true, so either strobe can be the one that opens it. The array is outside the block: its read data comes in on `arr_rdata` for the address on `rd_addr`. The control FSM has three states. ST_IDLE moves to ST_PROG on `prog_start` (transition PROG_GO) or to ST_ERASE on `erase_start` (transition ERASE_GO). ST_PROG and ST_ERASE return to ST_IDLE when the cycle timer reaches zero (transition OP_DONE). In every other case the state is held.

Top module: `flash_busy_status`

## Requirements
- R1: After reset `busy` is 0. `dout` is 8'h00 whenever `ce_n` or `oe_n` is high.
- R2: When `busy` is 0 and both strobes are low, `dout` equals `arr_rdata`.
- R3: A `prog_start` sampled in ST_IDLE makes `busy` high for exactly PROG_CYCLES clock cycles, counted from the next clock edge.
- R4: An `erase_start` sampled in ST_IDLE makes `busy` high for exactly ERASE_CYCLES clock cycles.
- R5: During a program, a read of the latched program address returns the inverse of bit 7 of the latched data on `dout[7]`.
- R6: During a program at any other address, and during an erase, `dout[7]` and `dout[5:0]` come from `arr_rdata`. `dout[5:0]` also comes from `arr_rdata` in the R5 case.
- R7: While `busy` is high, `dout[6]` is 1 on the first access after the operation starts and inverts on each later access.
- R8: Within one access, meaning both strobes held low, `dout[6]` does not change.
- R9: Start requests while `busy` is high are ignored. The busy duration and the latched address and data stay unchanged.
- R10: Once `busy` is low again, every bit of `dout`, bit 6 included, shows `arr_rdata`, and repeated reads give the same value.
- R11: If `prog_start` and `erase_start` arrive in the same ST_IDLE cycle, the program is taken.
- R12: A new access is counted whether it is opened by `ce_n` falling while `oe_n` is low, or by `oe_n` falling while `ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | Request a byte program, sampled in ST_IDLE |
| erase_start | input | 1 | Request an array erase, sampled in ST_IDLE |
| prog_addr | input | ADDR_W | Address of the byte being programmed |
| prog_data | input | DATA_W | Data of the byte being programmed |
| ce_n | input | 1 | Chip select strobe, active low |
| oe_n | input | 1 | Output enable strobe, active low |
| rd_addr | input | ADDR_W | Read address on the bus |
| arr_rdata | input | DATA_W | Array data for `rd_addr` |
| dout | output | DATA_W | Byte driven to the bus |
| busy | output | 1 | High while a program or erase runs |

## Verification
The assertions assume that the strobes and `rd_addr` change only between clock edges and stay constant for the whole of an access. They also assume a new operation is never requested in the same cycle that a read access opens, because the two would otherwise contend for the toggle register. The bench changes every input on the falling clock edge. It keeps each access open for several cycles with a fixed address and issues start requests only while the strobes are high. With those inputs, the toggle sequence and the polling bit can be predicted from the number of accesses counted since the start.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } op_state_t;
endpackage

// File: rtl/op_timer.sv
module op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R3, R4: a running count moves down by exactly one per cycle
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rd_toggle.sv
module rd_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic clr,
    output logic rd_active,
    output logic tog_bit
);
    logic rd_prev_q;
    logic tgl_q;
    logic rd_open;

    assign rd_active = !ce_n && !oe_n;
    assign rd_open   = rd_active && !rd_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_prev_q <= 1'b0;
            tgl_q     <= 1'b0;
        end else begin
            rd_prev_q <= rd_active;
            if (clr) begin
                tgl_q <= 1'b0;
            end else if (rd_open) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    // value seen during an access is the post-flip value from its first cycle
    assign tog_bit = tgl_q ^ rd_open;

    // R7: every opened access flips the stored toggle
    a_r7_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_open && !clr) |=> (tgl_q != $past(tgl_q)));

    // R8: toggle seen by the bus holds for the rest of an access
    a_r8_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active && $past(rd_active) && !$past(clr)) |-> $stable(tog_bit));
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
    import flash_status_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int DATA_W       = 8,
    parameter int PROG_CYCLES  = 500,
    parameter int ERASE_CYCLES = 500000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic              erase_start,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int POLL_B  = DATA_W - 1;
    localparam int TGL_B   = DATA_W - 2;
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYCLES);

    op_state_t         state_q, state_d;
    logic [ADDR_W-1:0] lat_addr_q;
    logic              lat_poll_q;
    logic              prog_go, erase_go, op_go;
    logic              tmr_done;
    logic              rd_active, tog_bit;
    logic              unused_bits;

    assign unused_bits = ^prog_data[DATA_W-2:0];

    // start decode: program wins a tie (R11), requests while busy dropped (R9)
    assign prog_go  = (state_q == ST_IDLE) && prog_start;
    assign erase_go = (state_q == ST_IDLE) && erase_start && !prog_start;
    assign op_go    = prog_go || erase_go;

    op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (op_go),
        .load_val (prog_go ? PROG_LD : ERASE_LD),
        .run      (busy),
        .done     (tmr_done)
    );

    rd_toggle u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .clr       (op_go),
        .rd_active (rd_active),
        .tog_bit   (tog_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (prog_go)       state_d = ST_PROG;
                else if (erase_go) state_d = ST_ERASE;
            end
            ST_PROG:  if (tmr_done) state_d = ST_IDLE;
            ST_ERASE: if (tmr_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and program latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            lat_addr_q <= '0;
            lat_poll_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (prog_go) begin
                lat_addr_q <= prog_addr;
                lat_poll_q <= prog_data[POLL_B];
            end
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        dout = '0;
        if (rd_active) begin
            dout = arr_rdata;
            unique case (state_q)
                ST_IDLE: ;
                ST_PROG: begin
                    dout[TGL_B] = tog_bit;
                    if (rd_addr == lat_addr_q) dout[POLL_B] = ~lat_poll_q;
                end
                ST_ERASE: dout[TGL_B] = tog_bit;
                default: dout = arr_rdata;
            endcase
        end
    end

    // R1: nothing driven outside an access
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (dout == '0));

    // R2, R10: idle reads carry array data
    a_r2_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_active) |-> (dout == arr_rdata));

    // R5: polling bit inverts the loaded bit at the loaded address
    a_r5_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && rd_active && rd_addr == lat_addr_q)
            |-> (dout[POLL_B] != lat_poll_q));

    // R9: latched program target stays put for the whole operation
    a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(lat_addr_q) && $stable(lat_poll_q)));

    // R4: erase only ends by returning to idle
    a_r4_erase_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_ERASE) |-> (state_q == ST_ERASE || state_q == ST_IDLE));
endmodule

// File: tb/flash_busy_status_bench.sv
module flash_busy_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int PROG_N  = 24;
    localparam int ERASE_N = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start = 1'b0, erase_start = 1'b0;
    logic [AW-1:0] prog_addr = '0, rd_addr = '0;
    logic [DW-1:0] prog_data = '0, arr_rdata;
    logic          ce_n = 1'b1, oe_n = 1'b1;
    logic [DW-1:0] dout;
    logic          busy;

    int n_chk = 0, n_bad = 0, busy_cnt = 0;
    logic tb_t;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // array model
    function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction
    assign arr_rdata = arr_of(rd_addr);

    always @(negedge clk) if (busy) busy_cnt++;

    flash_busy_status #(
        .ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)
    ) u_flash_busy_status (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
        .prog_addr(prog_addr), .prog_data(prog_data), .ce_n(ce_n), .oe_n(oe_n),
        .rd_addr(rd_addr), .arr_rdata(arr_rdata), .dout(dout), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic rd_open(input logic [AW-1:0] a);
        @(negedge clk);
        rd_addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #1;
    endtask

    task automatic rd_close();
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        #1;
    endtask

    // one busy read: expected byte given polling-bit value, checked twice
    task automatic busy_read(input string tag, input logic [AW-1:0] a, input logic b7);
        logic [DW-1:0] e;
        rd_open(a);
        tb_t = ~tb_t;
        e = {b7, tb_t, arr_of(a)[5:0]};
        chk(tag, dout, e);
        @(negedge clk); #1;
        chk("R8 bit6 held in access", dout, e);
        rd_close();
    endtask

    task automatic pulse_start(input logic p, input logic e, input logic [AW-1:0] a,
                               input logic [DW-1:0] d);
        @(negedge clk);
        prog_start = p; erase_start = e; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_start = 1'b0; erase_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        #1;
    endtask

    // {ce_n, oe_n, addr, expected dout} for idle reads
    localparam logic [26:0] VEC [6] = '{
        {1'b0, 1'b0, 17'h00000, 8'h3C},
        {1'b0, 1'b0, 17'h000FF, 8'hC3},
        {1'b0, 1'b0, 17'h05555, 8'h69},
        {1'b0, 1'b0, 17'h12AAA, 8'h96},
        {1'b1, 1'b0, 17'h01111, 8'h00},
        {1'b0, 1'b1, 17'h01111, 8'h00}
    };

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] pa;
        logic [DW-1:0] pd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 busy after reset", busy, 0);
        chk("R1 dout quiet after reset", dout, 8'h00);

        // R2 / R1 table walk
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ce_n = VEC[i][26]; oe_n = VEC[i][25]; rd_addr = VEC[i][24:8];
            #1;
            chk((VEC[i][26] | VEC[i][25]) ? "R1 one strobe high" : "R2 idle pass",
                dout, VEC[i][7:0]);
            @(negedge clk);
            ce_n = 1'b1; oe_n = 1'b1;
        end

        // program: R3, R5, R6, R7, R9, R10
        pa = 17'h01234; pd = 8'h5A;
        busy_cnt = 0; tb_t = 1'b0;
        pulse_start(1'b1, 1'b0, pa, pd);
        busy_read("R5/R7 poll at loaded addr", pa, ~pd[7]);
        busy_read("R6/R7 other addr in program", 17'h00077, arr_of(17'h00077)[7]);
        busy_read("R7 third access", pa, ~pd[7]);
        pulse_start(1'b1, 1'b1, 17'h00077, 8'hFF);   // ignored while busy
        busy_read("R9 latch kept after ignored start", pa, ~pd[7]);
        wait_idle();
        chk("R3 program busy cycles", busy_cnt, PROG_N);
        chk("R9 busy not extended", busy_cnt, PROG_N);
        rd_open(pa);
        chk("R10 true data after program", dout, arr_of(pa));
        rd_close();
        rd_open(pa);
        chk("R10 repeat read unchanged", dout, arr_of(pa));
        rd_close();

        // erase: R4, R6, R7
        busy_cnt = 0; tb_t = 1'b0;
        pulse_start(1'b0, 1'b1, pa, pd);
        busy_read("R6/R7 erase read", 17'h000B1, arr_of(17'h000B1)[7]);
        busy_read("R7 erase second access", 17'h000B1, arr_of(17'h000B1)[7]);
        busy_read("R6 erase at old program addr", pa, arr_of(pa)[7]);
        wait_idle();
        chk("R4 erase busy cycles", busy_cnt, ERASE_N);
        rd_open(17'h000B1);
        chk("R10 true data after erase", dout, arr_of(17'h000B1));
        rd_close();

        // R11: both requests together
        pa = 17'h0ABCD; pd = 8'hC3;
        busy_cnt = 0; tb_t = 1'b0;
        pulse_start(1'b1, 1'b1, pa, pd);
        busy_read("R11 program chosen, poll inverts", pa, ~pd[7]);
        wait_idle();
        chk("R11 program duration", busy_cnt, PROG_N);

        // R12: accesses opened by either strobe
        busy_cnt = 0; tb_t = 1'b0;
        pulse_start(1'b1, 1'b0, pa, pd);
        @(negedge clk); rd_addr = 17'h00020; oe_n = 1'b0; #1;
        chk("R1 oe low only", dout, 8'h00);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); ce_n = 1'b0; #1;
            tb_t = ~tb_t;
            chk("R12 access opened by ce_n", dout[6], tb_t);
            @(negedge clk); ce_n = 1'b1;
        end
        @(negedge clk); oe_n = 1'b1; ce_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); oe_n = 1'b0; #1;
            tb_t = ~tb_t;
            chk("R12 access opened by oe_n", dout[6], tb_t);
            @(negedge clk); oe_n = 1'b1;
        end
        @(negedge clk); ce_n = 1'b1;
        wait_idle();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule